// File: doc/BRIEF.md
# Serial Byte-Memory Slave with Write Protection

This block is the slave side of a four-wire serial memory (clock idle low, data sampled on the rising clock edge and shifted out after the falling edge). Its storage is 2048 bytes held in a register array. A fast system clock oversamples every pin. Chip select, serial clock, serial data in, the pause pin and the write-protect pin pass through two-stage synchronizers, and edges of the serial clock are found in the system-clock domain.

A transaction starts when chip select falls. It carries an 8-bit command and, for memory access, two address bytes. Read and write access advance through memory byte by byte. Writes are gated by a write-enable latch, by a two-bit protected-range field and by a status-protect bit that works with the write-protect pin. The pause pin freezes a transaction in place until it is released at the same clock level it was entered at.

The block moves serial bits, not a byte stream, so it has no valid/ready handshake. There is no back-pressure: the master owns the clock and the slave must keep pace with it.

Top module: `spi_nvram_slave`

## Requirements
- R1: Command 03h followed by two address bytes returns bytes MSB first from that address on; only the low 3 bits of the first address byte are used, the address increments per byte and wraps from 7FFh to 000h.
- R2: Command 02h with the enable latch set stores each complete data byte at a rising address (same wrap); a trailing partial byte is discarded.
- R3: Command 06h sets and 04h clears the enable latch once the eighth command bit is taken; with the latch clear, writes and status writes change nothing.
- R4: Command 05h returns the status byte repeatedly: bit 7 status-protect, bits 3:2 range field, bit 1 enable latch, other bits 0.
- R5: Range field 01 blocks writes to 600h-7FFh, 10 blocks 400h-7FFh, 11 blocks all addresses, 00 blocks none; the address still advances over blocked bytes.
- R6: Command 01h loads bits 7, 3 and 2 of its data byte into the status register only if the latch is set and either status-protect is 0 or wp_n is high.
- R7: Chip select rising after a recognized 02h or 01h command clears the enable latch, even if nothing was stored.
- R8: With cs_n low, hold_n low pauses the transaction. Clock and data edges are ignored and the state is kept. The pause ends only when hold_n is high and sck is at the level it had when the pause began.
- R9: so_oe is high only while a 03h or 05h command is in its data phase, cs_n is low and no pause is active.
- R10: Chip select rising during a pause aborts the transaction; a command not yet recognized leaves the enable latch unchanged.
- R11: Unknown commands are ignored until chip select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the master |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Pause request, active low |
| wp_n | input | 1 | Write-protect pin, low protects status when enabled |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for so; high-impedance when low |

## Verification
The assertions assume the pins change slowly against clk: each sck phase lasts several system clocks, hold_n and cs_n change only while sck is steady, and wp_n is stable during a status write. Under those conditions, every synchronized edge the logic sees is a real edge. The bench drives every pin from the falling system clock with eight-cycle phases. It moves cs_n only with sck low and toggles hold_n only between sck changes, so the stimulus stays inside these assumptions.

// File: rtl/smem_pkg.sv
package smem_pkg;

  typedef enum logic [2:0] {
    ST_OP,
    ST_AHI,
    ST_ALO,
    ST_RDSR,
    ST_WRSR,
    ST_READ,
    ST_WRITE,
    ST_SKIP
  } smem_st_e;

  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;

  // Range field against the two top address bits: 01 upper quarter,
  // 10 upper half, 11 everything.
  function automatic logic blk_locked(input logic [1:0] rng, input logic [1:0] top);
    case (rng)
      2'b01:   return top == 2'b11;
      2'b10:   return top[1];
      2'b11:   return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/smem_sync.sv
module smem_sync #(
  parameter int WIDTH = 5,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] q
);

  for (genvar gi = 0; gi < WIDTH; gi++) begin : g_bit
    logic meta, stab;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta <= RST_VAL[gi];
        stab <= RST_VAL[gi];
      end else begin
        meta <= d_in[gi];
        stab <= meta;
      end
    end
    assign q[gi] = stab;
  end

endmodule

// File: rtl/smem_hold.sv
module smem_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic hold_n,
  output logic held
);

  logic entry_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held      <= 1'b0;
      entry_lvl <= 1'b0;
    end else if (cs_n) begin
      held <= 1'b0;
    end else if (!held && !hold_n) begin
      held      <= 1'b1;
      entry_lvl <= sck;
    end else if (held && hold_n && (sck == entry_lvl)) begin
      held <= 1'b0;
    end
  end

  // R8: a pause persists until release at the entry clock level
  a_r8_hold_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !cs_n && (!hold_n || sck != entry_lvl)) |=> held);

  // R10: deselect always ends a pause
  a_r10_cs_ends_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !held);

endmodule

// File: rtl/smem_array.sv
module smem_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
  end

  assign rdata = cells[addr];

endmodule

// File: rtl/spi_nvram_slave.sv
module spi_nvram_slave
  import smem_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic hold_n,
  input  logic wp_n,
  output logic so,
  output logic so_oe
);

  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W);
  localparam int HI_W   = ADDR_W - BYTE_W;
  localparam int NPIN   = 5;

  // pin order: wp_n, hold_n, si, sck, cs_n (idle values 1,1,0,0,1)
  logic [NPIN-1:0] pins_raw, pins_syn;
  logic s_cs, s_sck, s_si, s_hold, s_wp;

  assign pins_raw = {wp_n, hold_n, si, sck, cs_n};

  smem_sync #(.WIDTH(NPIN), .RST_VAL(5'b11001)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_in (pins_raw),
    .q    (pins_syn)
  );

  assign s_cs   = pins_syn[0];
  assign s_sck  = pins_syn[1];
  assign s_si   = pins_syn[2];
  assign s_hold = pins_syn[3];
  assign s_wp   = pins_syn[4];

  logic hold_q;

  smem_hold u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .cs_n  (s_cs),
    .sck   (s_sck),
    .hold_n(s_hold),
    .held  (hold_q)
  );

  logic sck_d, cs_d;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d <= 1'b0;
      cs_d  <= 1'b1;
    end else begin
      sck_d <= s_sck;
      cs_d  <= s_cs;
    end
  end

  logic sck_rise, sck_fall, cs_rise;
  assign sck_rise = s_sck & ~sck_d & ~s_cs & ~hold_q;
  assign sck_fall = ~s_sck & sck_d & ~s_cs & ~hold_q;
  assign cs_rise  = s_cs & ~cs_d;

  smem_st_e             st;
  logic [CNT_W-1:0]     bitcnt;
  logic [BYTE_W-2:0]    rx_sh;
  logic [BYTE_W-1:0]    rx_byte;
  logic [ADDR_W-1:0]    addr;
  logic                 op_rd;
  logic                 wel, wpen, wclr;
  logic [1:0]           rng;
  logic [BYTE_W-1:0]    status;
  logic [BYTE_W-1:0]    mem_q;
  logic                 byte_done, locked, mem_we, sr_ok;

  assign rx_byte   = {rx_sh, s_si};
  assign byte_done = sck_rise && (bitcnt == CNT_W'(BYTE_W - 1));
  assign status    = {wpen, 3'b000, rng, wel, 1'b0};
  assign locked    = blk_locked(rng, addr[ADDR_W-1 -: 2]);
  assign mem_we    = byte_done && (st == ST_WRITE) && wel && !locked;
  assign sr_ok     = wel && (!wpen || s_wp);

  smem_array #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_mem (
    .clk  (clk),
    .we   (mem_we),
    .addr (addr),
    .wdata(rx_byte),
    .rdata(mem_q)
  );

  // command decode and receive path
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_OP;
      bitcnt <= '0;
      rx_sh  <= '0;
      addr   <= '0;
      op_rd  <= 1'b0;
      wel    <= 1'b0;
      wpen   <= 1'b0;
      rng    <= 2'b00;
      wclr   <= 1'b0;
    end else if (s_cs) begin
      st     <= ST_OP;
      bitcnt <= '0;
      if (cs_rise && wclr) wel <= 1'b0;
      wclr   <= 1'b0;
    end else if (sck_rise) begin
      bitcnt <= bitcnt + CNT_W'(1);
      rx_sh  <= rx_byte[BYTE_W-2:0];
      if (byte_done) begin
        case (st)
          ST_OP: begin
            case (rx_byte)
              OP_WREN:  begin wel <= 1'b1; st <= ST_SKIP; end
              OP_WRDI:  begin wel <= 1'b0; st <= ST_SKIP; end
              OP_RDSR:  st <= ST_RDSR;
              OP_WRSR:  begin wclr <= 1'b1; st <= ST_WRSR; end
              OP_READ:  begin op_rd <= 1'b1; st <= ST_AHI; end
              OP_WRITE: begin op_rd <= 1'b0; wclr <= 1'b1; st <= ST_AHI; end
              default:  st <= ST_SKIP;
            endcase
          end
          ST_AHI: begin
            addr[ADDR_W-1:BYTE_W] <= rx_byte[HI_W-1:0];
            st <= ST_ALO;
          end
          ST_ALO: begin
            addr[BYTE_W-1:0] <= rx_byte;
            st <= op_rd ? ST_READ : ST_WRITE;
          end
          ST_WRSR: begin
            if (sr_ok) begin
              wpen <= rx_byte[7];
              rng  <= rx_byte[3:2];
            end
            st <= ST_SKIP;
          end
          ST_READ, ST_WRITE: addr <= addr + ADDR_W'(1);
          default: ;
        endcase
      end
    end
  end

  // transmit path: a new byte is fetched on the first falling edge of each byte
  logic [BYTE_W-1:0] tx_byte;
  logic [BYTE_W-1:0] tx_src;
  logic              so_q;
  logic              rd_phase;

  assign rd_phase = (st == ST_READ) || (st == ST_RDSR);
  assign tx_src   = (st == ST_READ) ? mem_q : status;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_byte <= '0;
      so_q    <= 1'b0;
    end else if (sck_fall && rd_phase) begin
      if (bitcnt == '0) begin
        tx_byte <= tx_src;
        so_q    <= tx_src[BYTE_W-1];
      end else begin
        so_q <= tx_byte[~bitcnt];
      end
    end
  end

  assign so    = so_q;
  assign so_oe = ~s_cs & ~hold_q & rd_phase;

  // R3: status bits cannot move while the enable latch is clear
  a_r3_wel_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !wel |=> ($stable(wpen) && $stable(rng)));

  // R6: protected status with the pin low is frozen
  a_r6_wp_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (wpen && !s_wp) |=> ($stable(wpen) && $stable(rng)));

  // R7: deselect after a recognized write-type command drops the latch
  a_r7_wel_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && wclr) |=> !wel);

  // R8: a paused transaction keeps its position
  a_r8_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && !s_cs) |=> ($stable(bitcnt) && $stable(st) && $stable(addr)));

  // R5: the whole array is closed when the range field is 11
  a_r5_full_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (rng == 2'b11) |-> !mem_we);

endmodule

// File: tb/spi_nvram_slave_tb.sv
module spi_nvram_slave_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
  wire  so, so_oe;

  always #2 clk = ~clk;

  spi_nvram_slave u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .hold_n(hold_n), .wp_n(wp_n), .so(so), .so_oe(so_oe)
  );

  int errs = 0, checks = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] mon_sh = '0;
  logic [7:0] mon_e;
  string      mon_t;
  int         mon_n = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: assemble bytes at sck rise while output is enabled
  always @(posedge sck or posedge cs_n) begin
    if (cs_n) mon_n = 0;
    else if (so_oe) begin
      mon_sh = {mon_sh[6:0], so};
      mon_n++;
      if (mon_n == 8) begin
        mon_n = 0;
        if (exp_q.size() == 0) chk(1'b0, "unexpected byte", mon_sh, 0);
        else begin
          mon_e = exp_q.pop_front();
          mon_t = tag_q.pop_front();
          chk(mon_sh == mon_e, mon_t, mon_sh, mon_e);
        end
      end
    end
  end

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask
  task automatic spi_bit(input logic b);
    si = b; tick(8); sck = 1'b1; tick(8); sck = 1'b0;
  endtask
  task automatic spi_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) spi_bit(b[i]);
  endtask
  task automatic sel();   cs_n = 1'b0; tick(8); endtask
  task automatic desel(); tick(8); cs_n = 1'b1; tick(8); endtask
  task automatic push(input logic [7:0] b, input string tag);
    exp_q.push_back(b); tag_q.push_back(tag);
  endtask
  task automatic drained(input string tag);
    chk(exp_q.size() == 0, tag, exp_q.size(), 0);
    exp_q.delete(); tag_q.delete();
  endtask
  task automatic cmd(input logic [7:0] op); sel(); spi_byte(op); desel(); endtask
  task automatic wr(input logic [7:0] hi, input logic [7:0] lo,
                    input logic [7:0] d0, input logic [7:0] d1, input int n);
    sel(); spi_byte(8'h02); spi_byte(hi); spi_byte(lo);
    spi_byte(d0); if (n > 1) spi_byte(d1); desel();
  endtask
  task automatic rd(input logic [7:0] hi, input logic [7:0] lo, input int n,
                    input logic [7:0] e0, input logic [7:0] e1, input string tag);
    push(e0, tag); if (n > 1) push(e1, tag);
    sel(); spi_byte(8'h03); spi_byte(hi); spi_byte(lo);
    for (int i = 0; i < n; i++) spi_byte(8'h00);
    desel(); drained(tag);
  endtask
  task automatic rdsr(input logic [7:0] e, input string tag);
    push(e, tag); push(e, tag);
    sel(); spi_byte(8'h05); spi_byte(8'h00); spi_byte(8'h00); desel(); drained(tag);
  endtask
  task automatic wrsr(input logic [7:0] v);
    sel(); spi_byte(8'h01); spi_byte(v); desel();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    tick(5); rst_n = 1'b1; tick(5);
    chk(so_oe == 1'b0, "R9 reset oe", so_oe, 0);
    rdsr(8'h00, "R4 reset status");

    // write path and enable latch
    cmd(8'h06); wr(8'h00, 8'h10, 8'hA5, 8'h3C, 2);
    rd(8'h00, 8'h10, 2, 8'hA5, 8'h3C, "R2 write/read");
    rdsr(8'h00, "R7 latch cleared after write");
    wr(8'h00, 8'h10, 8'hFF, 8'h00, 1);
    rd(8'h00, 8'h10, 1, 8'hA5, 8'h00, "R3 write without latch");
    cmd(8'h06); rdsr(8'h02, "R3 latch set");
    cmd(8'h04); rdsr(8'h00, "R3 latch cleared");

    // wrap and ignored address bits
    cmd(8'h06); wr(8'hFF, 8'hFF, 8'h11, 8'h22, 2);
    rd(8'h07, 8'hFF, 2, 8'h11, 8'h22, "R1 wrap");
    rd(8'hF8, 8'h00, 1, 8'h22, 8'h00, "R1 upper address bits");

    // partial trailing byte
    cmd(8'h06);
    sel(); spi_byte(8'h02); spi_byte(8'h00); spi_byte(8'h10); spi_byte(8'h5A);
    for (int i = 0; i < 4; i++) spi_bit(1'b1);
    desel();
    rd(8'h00, 8'h10, 2, 8'h5A, 8'h3C, "R2 partial byte dropped");

    // protection ranges
    cmd(8'h06); wr(8'h03, 8'hFF, 8'h77, 8'h66, 2);
    cmd(8'h06); wr(8'h05, 8'hFF, 8'h88, 8'h55, 2);
    cmd(8'h06); wrsr(8'h04); rdsr(8'h04, "R6 range 01 loaded");
    cmd(8'h06); wr(8'h05, 8'hFF, 8'h99, 8'hAA, 2);
    rd(8'h05, 8'hFF, 2, 8'h99, 8'h55, "R5 quarter");
    cmd(8'h06); wrsr(8'h08);
    cmd(8'h06); wr(8'h03, 8'hFF, 8'hBB, 8'hCC, 2);
    rd(8'h03, 8'hFF, 2, 8'hBB, 8'h66, "R5 half");
    cmd(8'h06); wrsr(8'h0C);
    cmd(8'h06); wr(8'h00, 8'h00, 8'hEE, 8'h00, 1);
    rd(8'h00, 8'h00, 1, 8'h22, 8'h00, "R5 all");

    // status protection with the pin
    cmd(8'h06); wrsr(8'h8C); rdsr(8'h8C, "R6 status-protect set");
    wp_n = 1'b0; cmd(8'h06); wrsr(8'h00); rdsr(8'h8C, "R6 pin low blocks");
    wp_n = 1'b1; cmd(8'h06); wrsr(8'h00); rdsr(8'h00, "R6 pin high allows");
    wp_n = 1'b0; cmd(8'h06); wrsr(8'h04); rdsr(8'h04, "R6 pin ignored when unprotected");
    cmd(8'h06); wrsr(8'h00); wp_n = 1'b1; rdsr(8'h00, "R6 restore");

    // unknown command
    cmd(8'h06);
    sel(); spi_byte(8'hAB); spi_byte(8'h04); spi_byte(8'h02); desel();
    rdsr(8'h02, "R11 unknown command ignored");
    cmd(8'h04);

    // pause entered with sck low
    push(8'h5A, "R8 pause low");
    sel(); spi_byte(8'h03); spi_byte(8'h00); spi_byte(8'h10);
    for (int i = 0; i < 3; i++) spi_bit(1'b0);
    hold_n = 1'b0; tick(8);
    chk(so_oe == 1'b0, "R9 oe off in pause", so_oe, 0);
    spi_bit(1'b1); spi_bit(1'b0);
    hold_n = 1'b1; tick(8);
    chk(so_oe == 1'b1, "R8 released at low", so_oe, 1);
    for (int i = 0; i < 5; i++) spi_bit(1'b0);
    desel(); drained("R8 pause low");

    // pause entered with sck high
    push(8'h5A, "R8 pause high");
    sel(); spi_byte(8'h03); spi_byte(8'h00); spi_byte(8'h10);
    for (int i = 0; i < 3; i++) spi_bit(1'b0);
    si = 1'b0; tick(8); sck = 1'b1; tick(8);
    hold_n = 1'b0; tick(8);
    sck = 1'b0; tick(8);
    hold_n = 1'b1; tick(8);
    chk(so_oe == 1'b0, "R8 not released at wrong level", so_oe, 0);
    sck = 1'b1; tick(8);
    chk(so_oe == 1'b1, "R8 released at high", so_oe, 1);
    sck = 1'b0;
    for (int i = 0; i < 4; i++) spi_bit(1'b0);
    desel(); drained("R8 pause high");

    // abort during a pause
    cmd(8'h06); cmd(8'h04);
    sel(); for (int i = 0; i < 4; i++) spi_bit(1'b0);
    hold_n = 1'b0; tick(8); spi_bit(1'b1);
    cs_n = 1'b1; tick(8); hold_n = 1'b1; tick(8);
    rdsr(8'h00, "R10 unrecognized command aborted");
    cmd(8'h06);
    sel(); spi_byte(8'h02);
    hold_n = 1'b0; tick(8);
    cs_n = 1'b1; tick(8); hold_n = 1'b1; tick(8);
    rdsr(8'h00, "R7 recognized write aborted clears latch");
    rd(8'h00, 8'h10, 1, 8'h5A, 8'h00, "R10 data kept after abort");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule